// File: doc/BRIEF.md
# Five-Strike Watchdog Timer

This block is a system watchdog that does not reset the chip on the first lapse of its period. A programmable down counter runs on a selectable microsecond tick. Every time it runs out, a strike counter advances, an interrupt is raised and the counter reloads. Only the fifth consecutive lapse without service produces a system-reset request. Software therefore programs one fifth of the total timeout as the period. The interrupts from the earlier lapses give it four chances to react before the chip is reset.

Software drives the block through a small word-addressed register port. It selects the tick lane, sets the period, and issues start, stop and service (ping) commands. It can acknowledge the interrupt. It can read back the live counter, the strike count, and a ready-computed figure of the ticks remaining before reset. The write and read sides are plain strobes with no back-pressure. A write is accepted in the cycle its strobe is high. Read data returns exactly one cycle after the read strobe, and the port can take one read per cycle.

Register map (word index on the address pins):

| Index | Name | Access | Layout |
|---|---|---|---|
| 0 | SRCSEL | RW | [3:0] tick lane |
| 1 | PERIOD | RW | [28:0] period in ticks |
| 2 | STATUS | R | [0] running, [1] interrupt pending, [14:12] strike count |
| 3 | COMMAND | W | [0] start, [1] stop, [2] ping; reads 0 |
| 4 | COUNTER | R/W1C | [28:0] live counter, [30] interrupt pending; write 1 to [30] to acknowledge |
| 5 | TICKSLEFT | R | ticks left before reset |
| other | none | R | read 0 |

Top module: `multi_expiry_wdt`

## Requirements
- R1: A write to COMMAND with bit 0 set and bit 1 clear does three things: it loads the counter with PERIOD, sets the strike count to 0, and sets the running flag. It also clears any pending interrupt.
- R2: While running, each cycle in which the selected tick lane is high decrements the counter. A tick that finds the counter at 1 or 0 is a lapse instead: the counter reloads from PERIOD, the strike count rises by one and the interrupt output goes high.
- R3: A lapse taken while the strike count is 4 raises sys_rst_req_o for exactly one cycle, in the cycle after that tick. The block stops with counter, strike count and interrupt all zero. With PERIOD = 3 and a continuous tick, the pulse follows the 15th tick after start.
- R4: A ping (COMMAND bit 2) while running reloads the counter from PERIOD, zeroes the strike count and clears the interrupt. While stopped it has no effect.
- R5: COMMAND bit 1 stops the block and zeroes the counter, strike count and interrupt. It wins over bit 0 in the same write. While stopped, ticks change nothing and no interrupt or reset request appears.
- R6: Writing COUNTER with bit 30 set clears the pending interrupt without touching the counter or strike count. A lapse in the same cycle wins and leaves the interrupt set.
- R7: STATUS shows running at bit 0, interrupt pending at bit 1 and the strike count at bits 14:12. COUNTER shows the live counter at bits 28:0 and the interrupt pending at bit 30. All other bits read 0.
- R8: TICKSLEFT reads counter + (4 − strike count) × PERIOD while running, and 0 while stopped.
- R9: SRCSEL picks tick lane tick_i[SRCSEL]. A value of 4 or more selects no lane, so the counter does not move.
- R10: A start, stop or effective ping in a cycle suppresses that cycle's tick. A PERIOD or SRCSEL write affects the counter only from the next edge, and a new PERIOD is first used at the next load.
- R11: rd_valid_o is high in the cycle after each rd_en_i. rd_data_o then holds the register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| tick_i | input | NSRC | candidate tick enables, one per lane |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | register write index |
| wr_data_i | input | 32 | register write data |
| rd_en_i | input | 1 | register read strobe |
| rd_addr_i | input | 3 | register read index |
| rd_data_o | output | 32 | read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | interrupt: an intermediate lapse is pending |
| sys_rst_req_o | output | 1 | one-cycle system reset request |

## Verification
A wrong counter or strike count never shows on a pin by itself. It surfaces through TICKSLEFT, COUNTER and STATUS on the next read. Otherwise it appears as an interrupt or reset pulse that comes one lapse early or late, which can be up to a full period of ticks later. The bench therefore keeps a behavioural model and compares the interrupt and reset pins on every cycle. It reads registers at random points, so a diverging counter is caught within one read of the divergence rather than at the next lapse. A directed run with a period of 3 checks the tick count to the reset pulse as a literal number.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 4;

  localparam logic [ADDR_W-1:0] A_SRCSEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TLEFT  = 3'd5;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
  localparam int CMD_PING_BIT  = 2;
  localparam int ACK_BIT       = 30;
  localparam int ST_RUN_BIT    = 0;
  localparam int ST_IRQ_BIT    = 1;
  localparam int ST_STRIKE_LSB = 12;

  typedef struct packed {
    logic start;
    logic stop;
    logic ping;
    logic ack;
  } wdt_cmd_t;
endpackage

// File: rtl/mwdt_tick_sel.sv
module mwdt_tick_sel #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 4
) (
  input  logic [NSRC-1:0]  tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [NSRC-1:0] lane_hit;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_lane
      assign lane_hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
    end
  endgenerate

  assign tick_o = |lane_hit;
endmodule

// File: rtl/mwdt_core.sv
module mwdt_core
  import mwdt_pkg::*;
#(
  parameter int CNT_W    = 29,
  parameter int EXPIRIES = 5,
  localparam int EXP_W   = $clog2(EXPIRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wdt_cmd_t         cmd_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [EXP_W-1:0] strike_o,
  output logic             run_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam logic [EXP_W-1:0] LAST_STRIKE = EXP_W'(EXPIRIES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] strike_q, strike_d;
  logic             run_q, run_d, irq_q, irq_d, req_q, req_d;
  logic             lapse;

  assign lapse = run_q && tick_i && (cnt_q[CNT_W-1:1] == '0);

  always_comb begin
    cnt_d    = cnt_q;
    strike_d = strike_q;
    run_d    = run_q;
    irq_d    = irq_q;
    req_d    = 1'b0;
    if (cmd_i.stop) begin
      run_d = 1'b0; cnt_d = '0; strike_d = '0; irq_d = 1'b0;
    end else if (cmd_i.start) begin
      run_d = 1'b1; cnt_d = period_i; strike_d = '0; irq_d = 1'b0;
    end else if (cmd_i.ping && run_q) begin
      cnt_d = period_i; strike_d = '0; irq_d = 1'b0;
    end else begin
      if (cmd_i.ack) irq_d = 1'b0;
      if (lapse) begin
        if (strike_q == LAST_STRIKE) begin
          req_d = 1'b1; run_d = 1'b0; cnt_d = '0; strike_d = '0; irq_d = 1'b0;
        end else begin
          strike_d = strike_q + 1'b1; cnt_d = period_i; irq_d = 1'b1;
        end
      end else if (run_q && tick_i) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0; strike_q <= '0; run_q <= 1'b0; irq_q <= 1'b0; req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; strike_q <= strike_d; run_q <= run_d; irq_q <= irq_d; req_q <= req_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign strike_o  = strike_q;
  assign run_o     = run_q;
  assign irq_o     = irq_q;
  assign rst_req_o = req_q;

  // R3: the reset request lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R3: the request only follows a lapse at the last strike
  a_r3_from_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> ($past(strike_q) == LAST_STRIKE) && !run_q && (cnt_q == '0));
  // R2: strike count never passes the last strike
  a_r2_strike_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strike_q <= LAST_STRIKE);
  // R5: a stopped block holds everything at zero
  a_r5_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!irq_q && cnt_q == '0 && strike_q == '0));
  // R4: a ping while running clears the strike count
  a_r4_ping_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.ping && run_q && !cmd_i.stop) |=> (strike_q == '0 && !irq_q));
endmodule

// File: rtl/mwdt_timeleft.sv
module mwdt_timeleft #(
  parameter int CNT_W    = 29,
  parameter int EXPIRIES = 5,
  parameter int OUT_W    = 32,
  localparam int EXP_W   = $clog2(EXPIRIES)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [EXP_W-1:0] strike_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             run_i,
  output logic [OUT_W-1:0] left_o
);
  logic [EXP_W-1:0] remaining;
  logic [OUT_W-1:0] span;

  assign remaining = EXP_W'(EXPIRIES - 1) - strike_i;
  assign span      = OUT_W'(period_i) * OUT_W'(remaining);
  assign left_o    = run_i ? (OUT_W'(cnt_i) + span) : '0;
endmodule

// File: rtl/mwdt_regif.sv
module mwdt_regif
  import mwdt_pkg::*;
#(
  parameter int CNT_W    = 29,
  parameter int EXPIRIES = 5,
  localparam int EXP_W   = $clog2(EXPIRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [EXP_W-1:0]  strike_i,
  input  logic              run_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] left_i,
  output wdt_cmd_t          cmd_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  period_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  period_q;
  logic [DATA_W-1:0] rdata_q, rmux;
  logic              rvalid_q;
  logic              cmd_wr;

  assign cmd_wr        = wr_en_i && (wr_addr_i == A_CMD);
  assign cmd_o.start   = cmd_wr && wr_data_i[CMD_START_BIT];
  assign cmd_o.stop    = cmd_wr && wr_data_i[CMD_STOP_BIT];
  assign cmd_o.ping    = cmd_wr && wr_data_i[CMD_PING_BIT];
  assign cmd_o.ack     = wr_en_i && (wr_addr_i == A_COUNT) && wr_data_i[ACK_BIT];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      period_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_SRCSEL) sel_q    <= wr_data_i[SEL_W-1:0];
      if (wr_addr_i == A_PERIOD) period_q <= wr_data_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    unique case (rd_addr_i)
      A_SRCSEL: rmux[SEL_W-1:0] = sel_q;
      A_PERIOD: rmux[CNT_W-1:0] = period_q;
      A_STATUS: begin
        rmux[ST_RUN_BIT] = run_i;
        rmux[ST_IRQ_BIT] = irq_i;
        rmux[ST_STRIKE_LSB +: EXP_W] = strike_i;
      end
      A_COUNT: begin
        rmux[CNT_W-1:0] = cnt_i;
        rmux[ACK_BIT]   = irq_i;
      end
      A_TLEFT: rmux = left_i;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rmux;
    end
  end

  assign rd_data_o  = rdata_q;
  assign rd_valid_o = rvalid_q;
  assign sel_o      = sel_q;
  assign period_o   = period_q;

  // R11: read data valid follows the read strobe by one cycle
  a_r11_rd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i));
  // R10: a PERIOD write is visible on the next cycle
  a_r10_period_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PERIOD) |=> period_o == $past(wr_data_i[CNT_W-1:0]));
endmodule

// File: rtl/multi_expiry_wdt.sv
module multi_expiry_wdt
  import mwdt_pkg::*;
#(
  parameter int NSRC     = 4,
  parameter int CNT_W    = 29,
  parameter int EXPIRIES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   tick_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  localparam int EXP_W = $clog2(EXPIRIES);

  wdt_cmd_t         cmd;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] period, cnt;
  logic [EXP_W-1:0] strike;
  logic             run, irq, tick;
  logic [DATA_W-1:0] left;

  mwdt_regif #(.CNT_W(CNT_W), .EXPIRIES(EXPIRIES)) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .cnt_i(cnt), .strike_i(strike), .run_i(run), .irq_i(irq), .left_i(left),
    .cmd_o(cmd), .sel_o(sel), .period_o(period)
  );

  mwdt_tick_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_tick (
    .tick_i(tick_i), .sel_i(sel), .tick_o(tick)
  );

  mwdt_core #(.CNT_W(CNT_W), .EXPIRIES(EXPIRIES)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cmd_i(cmd),
    .period_i(period), .cnt_o(cnt), .strike_o(strike), .run_o(run),
    .irq_o(irq), .rst_req_o(sys_rst_req_o)
  );

  mwdt_timeleft #(.CNT_W(CNT_W), .EXPIRIES(EXPIRIES), .OUT_W(DATA_W)) u_left (
    .cnt_i(cnt), .strike_i(strike), .period_i(period), .run_i(run), .left_o(left)
  );

  assign irq_o = irq;

  // R5: no interrupt and no reset request while stopped
  a_r5_no_irq_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !$past(run)) |-> !sys_rst_req_o && !irq_o);
  // R8: ticks-left is zero whenever stopped
  a_r8_left_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> left == '0);
endmodule

// File: tb/multi_expiry_wdt_tb_top.sv
module multi_expiry_wdt_tb_top;
  localparam int NSRC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  wa = '0, ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd_data;
  logic        rd_valid, irq, sysrst;

  int checks = 0, errors = 0;
  int tick_pct = 0;
  bit tick_all = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  multi_expiry_wdt #(.NSRC(NSRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .irq_o(irq), .sys_rst_req_o(sysrst)
  );

  // behavioural reference model
  int m_cnt, m_exp, m_per, m_src;
  bit m_run, m_irq, m_rst, m_rdv;
  logic [31:0] m_rd;

  function automatic logic [31:0] mread(int a);
    case (a)
      0: return 32'(m_src);
      1: return 32'(m_per);
      2: return 32'((m_exp << 12) | (int'(m_irq) << 1) | int'(m_run));
      4: return 32'((int'(m_irq) << 30) | m_cnt);
      5: return m_run ? 32'(m_cnt + (4 - m_exp) * m_per) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_exp = 0; m_per = 0; m_src = 0;
      m_run = 0; m_irq = 0; m_rst = 0; m_rdv = 0; m_rd = '0;
    end else begin
      bit tk, cmd_eff;
      int old_per;
      m_rdv = re;
      if (re) m_rd = mread(int'(ra));
      m_rst = 0;
      tk = (m_src < NSRC) && tick[m_src];
      old_per = m_per;
      cmd_eff = 0;
      if (we) begin
        case (wa)
          3'd0: m_src = int'(wd[3:0]);
          3'd1: m_per = int'(wd[28:0]);
          3'd3: begin
            if (wd[1]) begin m_run = 0; m_cnt = 0; m_exp = 0; m_irq = 0; cmd_eff = 1; end
            else if (wd[0]) begin m_run = 1; m_cnt = old_per; m_exp = 0; m_irq = 0; cmd_eff = 1; end
            else if (wd[2] && m_run) begin m_cnt = old_per; m_exp = 0; m_irq = 0; cmd_eff = 1; end
          end
          3'd4: if (wd[30]) m_irq = 0;
          default: ;
        endcase
      end
      if (!cmd_eff && m_run && tk) begin
        if (m_cnt <= 1) begin
          if (m_exp == 4) begin m_rst = 1; m_run = 0; m_cnt = 0; m_exp = 0; m_irq = 0; end
          else begin m_exp++; m_cnt = old_per; m_irq = 1; end
        end else m_cnt--;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(int a);
    case (a)
      0: return "R9";
      1: return "R10";
      2, 4: return "R7";
      5: return "R8";
      default: return "R11";
    endcase
  endfunction

  logic [2:0] last_ra = '0;
  always @(posedge clk) if (re) last_ra <= ra;

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(irq == m_irq, "R2 irq_o", 32'(irq), 32'(m_irq));
      check(sysrst == m_rst, "R3 sys_rst_req_o", 32'(sysrst), 32'(m_rst));
      check(rd_valid == m_rdv, "R11 rd_valid_o", 32'(rd_valid), 32'(m_rdv));
      if (rd_valid && m_rdv)
        check(rd_data == m_rd, rd_tag(int'(last_ra)), rd_data, m_rd);
    end
  end

  task automatic step(bit w, logic [2:0] a, logic [31:0] d, bit r, logic [2:0] q);
    @(negedge clk);
    we = w; wa = a; wd = d; re = r; ra = q;
    for (int i = 0; i < 4; i++)
      tick[i] = tick_all ? 1'b1 : ($urandom_range(99) < tick_pct);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, 0, 0, 3'd0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1, a, d, 0, 3'd0);
  endtask

  task automatic rd_now(logic [2:0] a, output logic [31:0] v);
    step(0, 3'd0, 0, 1, a);
    @(posedge clk); #1;
    v = rd_data;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    finished = 1;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int hit;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state (R7, R8)
    rd_now(3'd2, v); check(v == 0, "R7 reset STATUS", v, 0);
    rd_now(3'd5, v); check(v == 0, "R8 reset TICKSLEFT", v, 0);

    // R1: start loads the period
    tick_pct = 0;
    wr(3'd1, 10); wr(3'd3, 32'h1);
    rd_now(3'd4, v); check(v[28:0] == 10, "R1 counter after start", v, 10);
    rd_now(3'd2, v); check(v[0] == 1'b1, "R1 running after start", v, 1);
    rd_now(3'd5, v); check(v == 50, "R8 ticks-left after start", v, 50);

    // R2: three ticks on lane 0
    tick_all = 1; idle(3); tick_all = 0; tick_pct = 0;
    rd_now(3'd4, v); check(v[28:0] == 7, "R2 counter after 3 ticks", v, 7);

    // R10: period change is used only at the next load
    wr(3'd1, 4);
    rd_now(3'd4, v); check(v[28:0] == 7, "R10 counter unchanged by PERIOD write", v, 7);
    tick_all = 1; idle(7); tick_all = 0;
    rd_now(3'd4, v); check(v[28:0] == 4, "R10 reload uses new period", v, 4);
    rd_now(3'd2, v); check(v[14:12] == 1 && v[1], "R2 strike 1 and irq", v, 32'h1002 | 1);

    // R6: acknowledge clears irq, keeps strike count
    wr(3'd4, 32'h4000_0000);
    rd_now(3'd2, v); check(v == 32'h1001, "R6 ack leaves strike", v, 32'h1001);

    // R4: ping reloads and clears
    tick_all = 1; idle(4); tick_all = 0;
    wr(3'd3, 32'h4);
    rd_now(3'd2, v); check(v == 32'h1, "R4 ping clears strike/irq", v, 1);

    // R3: period 3, continuous tick -> reset after 15 ticks
    wr(3'd1, 3); wr(3'd3, 32'h1);
    tick_all = 1; hit = 0;
    for (int n = 1; n <= 20; n++) begin
      step(0, 3'd0, 0, 0, 3'd0);
      @(posedge clk); #1;
      if (sysrst && hit == 0) hit = n;
    end
    tick_all = 0;
    check(hit == 15, "R3 ticks to reset pulse", hit, 15);
    rd_now(3'd2, v); check(v == 0, "R3 stopped after reset", v, 0);

    // R5: stopped ignores ticks and ping; stop wins over start
    tick_all = 1; idle(30); tick_all = 0;
    wr(3'd3, 32'h4);
    rd_now(3'd4, v); check(v == 0, "R5 stopped counter", v, 0);
    wr(3'd3, 32'h3);
    rd_now(3'd2, v); check(v == 0, "R5 stop beats start", v, 0);

    // R9: lane select and invalid lane
    wr(3'd1, 20); wr(3'd0, 2); wr(3'd3, 32'h1);
    @(negedge clk); we = 0; tick = 4'b0001; repeat (5) @(negedge clk);
    rd_now(3'd4, v); check(v[28:0] == 20, "R9 other lane ignored", v, 20);
    tick_all = 1; idle(5); tick_all = 0;
    rd_now(3'd4, v); check(v[28:0] == 15, "R9 selected lane counts", v, 15);
    wr(3'd0, 9); tick_all = 1; idle(10); tick_all = 0;
    rd_now(3'd4, v); check(v[28:0] == 15, "R9 invalid lane stops count", v, 15);

    // random traffic checked cycle by cycle against the model
    wr(3'd0, 0); wr(3'd1, 2); wr(3'd3, 1);
    tick_pct = 60;
    for (int i = 0; i < 6000; i++) begin
      bit w, r;
      logic [2:0] a;
      logic [31:0] d;
      w = ($urandom_range(99) < 4);
      r = ($urandom_range(99) < 35);
      a = 3'($urandom_range(0, 5));
      case (a)
        3'd0: d = 32'($urandom_range(0, 5));
        3'd1: d = 32'($urandom_range(0, 9));
        3'd3: begin
          int p = $urandom_range(0, 9);
          d = (p < 4) ? 32'h1 : (p < 7) ? 32'h4 : (p == 7) ? 32'h2 : 32'h3;
        end
        3'd4: d = {1'b0, 1'($urandom_range(0, 1)), 30'h0};
        default: d = $urandom;
      endcase
      step(w, a, d, r, 3'($urandom_range(0, 7)));
    end
    idle(3);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule